// File: doc/BRIEF.md
# Clock Tree Frequency Calculator

This block works out, on request, the nominal frequency in hertz of one branch of a clock tree. The frequency follows from the settings held in four control words. The root is a 24 MHz crystal. A system PLL multiplies the crystal frequency by 20 or 22. Two fractional dividers derive further clocks from the PLL, each scaling it by 18 over a 6-bit fraction. A 2-bit selector picks the peripheral root from these sources. Three integer post-dividers in series then give the bus clock, the IPG clock and the per-clock.

A requester presents a clock identifier with `req_valid` while `req_ready` is high. After a variable number of cycles the block pulses `resp_valid` for one cycle with the 32-bit frequency and an error flag. The crystal, divided-crystal and slow constants come back on the cycle after acceptance. The computed branches go through one shared restoring divider that produces one quotient bit per cycle, so a deep branch takes a few hundred cycles. The control words are sampled when the request is accepted.

Top module: `clk_freq_calc`

## Requirements
- R1: Identifier 5 returns 24000000, identifier 6 returns 3000000 and identifier 7 returns 32768. Each of these responses has the error flag low.
- R2: Identifier 1 (peripheral root) with source select 0 returns the PLL frequency. That is 528000000 when bit 0 of `pll_ctrl` is 1, and 480000000 when it is 0.
- R3: The source select sits in bits 19:18 of `bus_div_ctrl`. Value 1 selects fractional output B, whose fraction is in bits 21:16 of `pfd_ctrl`. Value 2 selects fractional output A, whose fraction is in bits 5:0. Each fractional output equals floor(PLL × 18 / fraction).
- R4: Source select 3 returns fractional output B halved, with the halving applied after the division and truncating.
- R5: Identifier 2 (bus clock) returns floor(peripheral root / (1 + bits 12:10 of `bus_div_ctrl`)).
- R6: Identifier 3 (IPG clock) returns floor(bus clock / (1 + bits 9:8 of `bus_div_ctrl`)).
- R7: Identifier 4 (per-clock) returns floor(IPG clock / (1 + bits 5:0 of `per_div_ctrl`)). The full per-clock divider range 0 to 63 is honoured.
- R8: Identifier 0 and identifiers 8 to 15 return 0 with the error flag low.
- R9: If the selected fractional output has a fraction of 0, a request for identifiers 1 to 4 completes with the value 0 and the error flag high. A zero fraction on the source that is not selected has no effect.
- R10: `req_ready` is low from acceptance until the response. A `req_valid` presented while `req_ready` is low is ignored and alters neither the result nor the number of responses. Each accepted request gives exactly one single-cycle `resp_valid` pulse.
- R11: The returned value is the low 32 bits of the computed frequency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | High when a request can be accepted |
| req_clk_id | input | 4 | Clock identifier to evaluate |
| pll_ctrl | input | 32 | PLL control word (bit 0 multiplier select) |
| pfd_ctrl | input | 32 | Fraction control word (bits 5:0 A, 21:16 B) |
| bus_div_ctrl | input | 32 | Source select and bus/IPG divider fields |
| per_div_ctrl | input | 32 | Per-clock divider field (bits 5:0) |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_hz | output | 32 | Frequency in hertz |
| resp_err | output | 1 | Zero-fraction error, valid with resp_valid |

## Verification
A wrong stage counter or depth register shows up as a frequency divided once too often or once too few times. That is visible on the very next response for identifiers 2 to 4. A corrupted quotient register or a fault in the divider's restore step skews every computed branch, and it appears at the end of the first division, because the bench checks each response against an independently computed floor chain. A handshake fault, such as a lost busy state or a double pulse, is caught by comparing the count of `resp_valid` pulses with the count of accepted requests. It is also caught by the busy-window test, which drives a different identifier while the block is busy.

// File: rtl/clkcalc_pkg.sv
package clkcalc_pkg;

  typedef enum logic [3:0] {
    CID_NONE      = 4'd0,
    CID_PERIPH    = 4'd1,
    CID_BUS       = 4'd2,
    CID_IPG       = 4'd3,
    CID_PER       = 4'd4,
    CID_XTAL      = 4'd5,
    CID_XTAL_DIV8 = 4'd6,
    CID_SLOW      = 4'd7
  } clk_id_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PFD_WAIT,
    ST_POST_START,
    ST_POST_WAIT
  } calc_state_t;

  localparam int unsigned XTAL_HZ    = 24000000;
  localparam int unsigned SLOW_HZ    = 32768;
  localparam int unsigned XTAL_SHIFT = 3;
  localparam int unsigned PLL_MUL_HI = 22;
  localparam int unsigned PLL_MUL_LO = 20;
  localparam int unsigned PFD_MUL    = 18;
  localparam int unsigned N_POST     = 3;

  // Number of post-divider stages between the peripheral root and the branch.
  function automatic logic [1:0] chain_depth(input clk_id_t id);
    case (id)
      CID_BUS: chain_depth = 2'd1;
      CID_IPG: chain_depth = 2'd2;
      CID_PER: chain_depth = 2'd3;
      default: chain_depth = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/clkcalc_cfg_dec.sv
module clkcalc_cfg_dec
  import clkcalc_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int ACC_W  = 64,
  parameter int FRAC_W = 6,
  parameter int DIV_W  = 7
) (
  input  logic [REG_W-1:0]  pll_ctrl,
  input  logic [REG_W-1:0]  pfd_ctrl,
  input  logic [REG_W-1:0]  bus_div_ctrl,
  input  logic [REG_W-1:0]  per_div_ctrl,
  output logic [ACC_W-1:0]  pll_hz,
  output logic              use_pfd,
  output logic              halve,
  output logic [FRAC_W-1:0] frac,
  output logic [DIV_W-1:0]  post_div [N_POST]
);

  localparam int FRAC_A_LSB = 0;
  localparam int FRAC_B_LSB = 16;
  localparam int SEL_LSB    = 18;
  localparam int STAGE_LSB [N_POST] = '{10, 8, 0};
  localparam int STAGE_WID [N_POST] = '{3, 2, 6};

  logic [1:0] src_sel;
  logic [REG_W-1:0] stage_src [N_POST];

  assign src_sel = bus_div_ctrl[SEL_LSB +: 2];
  assign pll_hz  = pll_ctrl[0] ? ACC_W'(XTAL_HZ) * ACC_W'(PLL_MUL_HI)
                               : ACC_W'(XTAL_HZ) * ACC_W'(PLL_MUL_LO);
  assign use_pfd = (src_sel != 2'd0);
  assign halve   = (src_sel == 2'd3);
  assign frac    = (src_sel == 2'd2) ? pfd_ctrl[FRAC_A_LSB +: FRAC_W]
                                     : pfd_ctrl[FRAC_B_LSB +: FRAC_W];

  assign stage_src[0] = bus_div_ctrl;
  assign stage_src[1] = bus_div_ctrl;
  assign stage_src[2] = per_div_ctrl;

  for (genvar g = 0; g < N_POST; g++) begin : g_stage
    assign post_div[g] = DIV_W'(1) + DIV_W'(stage_src[g][STAGE_LSB[g] +: STAGE_WID[g]]);
  end

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^{pll_ctrl[REG_W-1:1], pfd_ctrl[REG_W-1:22], pfd_ctrl[15:6],
                             bus_div_ctrl[REG_W-1:20], bus_div_ctrl[17:13],
                             bus_div_ctrl[7:0], per_div_ctrl[REG_W-1:6]};

endmodule

// File: rtl/clkcalc_seq_div.sv
module clkcalc_seq_div #(
  parameter int NUM_W = 64,
  parameter int DEN_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             busy,
  output logic             done,
  output logic [NUM_W-1:0] quo
);

  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] quo_q;
  logic [DEN_W-1:0] rem_q;
  logic [DEN_W-1:0] den_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             done_q;
  logic [DEN_W:0]   trial;
  logic             take;

  assign trial = {rem_q, quo_q[NUM_W-1]};
  assign take  = (trial >= {1'b0, den_q});

  always_ff @(posedge clk) begin
    if (rst) begin
      quo_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        quo_q  <= num;
        rem_q  <= '0;
        den_q  <= den;
        cnt_q  <= CNT_W'(NUM_W);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        quo_q <= {quo_q[NUM_W-2:0], take};
        rem_q <= take ? DEN_W'(trial - {1'b0, den_q}) : trial[DEN_W-1:0];
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign quo  = quo_q;

  // R3: a finished restoring division always leaves a remainder below the divisor
  assert_rem_bound_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> (rem_q < den_q))
    else $error("divider remainder not below divisor");

endmodule

// File: rtl/clk_freq_calc.sv
module clk_freq_calc
  import clkcalc_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int ACC_W  = 64,
  parameter int FRAC_W = 6,
  parameter int DIV_W  = 7,
  parameter int OUT_W  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [3:0]       req_clk_id,
  input  logic [REG_W-1:0] pll_ctrl,
  input  logic [REG_W-1:0] pfd_ctrl,
  input  logic [REG_W-1:0] bus_div_ctrl,
  input  logic [REG_W-1:0] per_div_ctrl,
  output logic             resp_valid,
  output logic [OUT_W-1:0] resp_hz,
  output logic             resp_err
);

  logic [ACC_W-1:0]  dec_pll;
  logic              dec_use_pfd;
  logic              dec_halve;
  logic [FRAC_W-1:0] dec_frac;
  logic [DIV_W-1:0]  dec_post [N_POST];

  clkcalc_cfg_dec #(
    .REG_W(REG_W), .ACC_W(ACC_W), .FRAC_W(FRAC_W), .DIV_W(DIV_W)
  ) u_dec (
    .pll_ctrl(pll_ctrl), .pfd_ctrl(pfd_ctrl),
    .bus_div_ctrl(bus_div_ctrl), .per_div_ctrl(per_div_ctrl),
    .pll_hz(dec_pll), .use_pfd(dec_use_pfd), .halve(dec_halve),
    .frac(dec_frac), .post_div(dec_post)
  );

  calc_state_t      state_q;
  clk_id_t          id_q;
  logic [1:0]       depth_q;
  logic [1:0]       stage_q;
  logic             halve_q;
  logic [ACC_W-1:0] acc_q;
  logic [DIV_W-1:0] pdiv_q [N_POST];
  logic             go_q;
  logic [ACC_W-1:0] num_q;
  logic [DIV_W-1:0] den_q;
  logic             rv_q;
  logic [OUT_W-1:0] hz_q;
  logic             err_q;

  logic             div_busy;
  logic             div_done;
  logic [ACC_W-1:0] div_quo;
  logic [ACC_W-1:0] pfd_val;
  clk_id_t          req_id;
  logic [1:0]       req_depth;

  clkcalc_seq_div #(.NUM_W(ACC_W), .DEN_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .start(go_q), .num(num_q), .den(den_q),
    .busy(div_busy), .done(div_done), .quo(div_quo)
  );

  assign req_id    = clk_id_t'(req_clk_id);
  assign req_depth = chain_depth(req_id);
  assign pfd_val   = halve_q ? (div_quo >> 1) : div_quo;
  assign req_ready = (state_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      id_q    <= CID_NONE;
      depth_q <= '0;
      stage_q <= '0;
      halve_q <= 1'b0;
      acc_q   <= '0;
      go_q    <= 1'b0;
      num_q   <= '0;
      den_q   <= '0;
      rv_q    <= 1'b0;
      hz_q    <= '0;
      err_q   <= 1'b0;
      for (int i = 0; i < N_POST; i++) pdiv_q[i] <= '0;
    end else begin
      go_q  <= 1'b0;
      rv_q  <= 1'b0;
      err_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            id_q    <= req_id;
            depth_q <= req_depth;
            stage_q <= '0;
            halve_q <= dec_halve;
            for (int i = 0; i < N_POST; i++) pdiv_q[i] <= dec_post[i];
            case (req_id)
              CID_XTAL: begin
                rv_q <= 1'b1;
                hz_q <= OUT_W'(XTAL_HZ);
              end
              CID_XTAL_DIV8: begin
                rv_q <= 1'b1;
                hz_q <= OUT_W'(XTAL_HZ >> XTAL_SHIFT);
              end
              CID_SLOW: begin
                rv_q <= 1'b1;
                hz_q <= OUT_W'(SLOW_HZ);
              end
              CID_PERIPH, CID_BUS, CID_IPG, CID_PER: begin
                if (!dec_use_pfd) begin
                  if (req_depth == 2'd0) begin
                    rv_q <= 1'b1;
                    hz_q <= OUT_W'(dec_pll);
                  end else begin
                    acc_q   <= dec_pll;
                    state_q <= ST_POST_START;
                  end
                end else if (dec_frac == '0) begin
                  rv_q  <= 1'b1;
                  hz_q  <= '0;
                  err_q <= 1'b1;
                end else begin
                  go_q    <= 1'b1;
                  num_q   <= dec_pll * ACC_W'(PFD_MUL);
                  den_q   <= DIV_W'(dec_frac);
                  state_q <= ST_PFD_WAIT;
                end
              end
              default: begin
                rv_q <= 1'b1;
                hz_q <= '0;
              end
            endcase
          end
        end
        ST_PFD_WAIT: begin
          if (div_done) begin
            if (depth_q == 2'd0) begin
              rv_q    <= 1'b1;
              hz_q    <= OUT_W'(pfd_val);
              state_q <= ST_IDLE;
            end else begin
              acc_q   <= pfd_val;
              state_q <= ST_POST_START;
            end
          end
        end
        ST_POST_START: begin
          go_q    <= 1'b1;
          num_q   <= acc_q;
          den_q   <= pdiv_q[stage_q];
          state_q <= ST_POST_WAIT;
        end
        ST_POST_WAIT: begin
          if (div_done) begin
            if (stage_q == depth_q - 2'd1) begin
              rv_q    <= 1'b1;
              hz_q    <= OUT_W'(div_quo);
              state_q <= ST_IDLE;
            end else begin
              acc_q   <= div_quo;
              stage_q <= stage_q + 2'd1;
              state_q <= ST_POST_START;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign resp_valid = rv_q;
  assign resp_hz    = hz_q;
  assign resp_err   = err_q;

  // R9: the error flag only accompanies a zero-valued response
  assert_err_zero_R9: assert property (@(posedge clk) disable iff (rst)
    resp_err |-> (resp_valid && resp_hz == '0))
    else $error("error flag without zero response");

  // R1: a crystal-frequency response carries the fixed reference value
  assert_xtal_const_R1: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && id_q == CID_XTAL) |-> (resp_hz == OUT_W'(XTAL_HZ)))
    else $error("crystal constant wrong");

  // R10: a response only follows an accepted request or a computation in flight
  assert_resp_cause_R10: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> ($past(req_valid && req_ready) || $past(state_q != ST_IDLE)))
    else $error("response without request");

  // R10: while idle and ready, the shared divider holds no pending work
  assert_idle_div_R10: assert property (@(posedge clk) disable iff (rst)
    (req_ready && !$past(go_q)) |-> !div_busy)
    else $error("divider busy while idle");

endmodule

// File: tb/clk_freq_calc_bench.sv
module clk_freq_calc_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_clk_id = 4'd0;
  logic [31:0] pll_ctrl = 32'd0;
  logic [31:0] pfd_ctrl = 32'd0;
  logic [31:0] bus_div_ctrl = 32'd0;
  logic [31:0] per_div_ctrl = 32'd0;
  logic        resp_valid;
  logic [31:0] resp_hz;
  logic        resp_err;

  int n_checks = 0;
  int n_fails  = 0;
  int n_issued = 0;
  int n_resps  = 0;
  int cycles   = 0;

  always #10 clk = ~clk;

  clk_freq_calc u_clk_freq_calc (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_clk_id(req_clk_id), .pll_ctrl(pll_ctrl), .pfd_ctrl(pfd_ctrl),
    .bus_div_ctrl(bus_div_ctrl), .per_div_ctrl(per_div_ctrl),
    .resp_valid(resp_valid), .resp_hz(resp_hz), .resp_err(resp_err)
  );

  // every clock: count pulses and check the error flag never appears alone
  always @(negedge clk) begin
    cycles++;
    if (!rst && resp_valid) n_resps++;
    if (!rst && resp_err && !resp_valid) begin
      n_fails++;
      $display("FAIL R9 err=%0d valid=%0d expected valid=1", resp_err, resp_valid);
    end
    if (cycles > 150000) begin
      n_fails++;
      $display("FAIL watchdog expired after %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  function automatic void model(input int id, output longint unsigned hz, output bit err);
    longint unsigned pll, p, f;
    int sel;
    err = 0;
    hz  = 0;
    pll = pll_ctrl[0] ? 64'd528000000 : 64'd480000000;
    sel = bus_div_ctrl[19:18];
    case (id)
      5: hz = 24000000;
      6: hz = 3000000;
      7: hz = 32768;
      1, 2, 3, 4: begin
        if (sel == 0) p = pll;
        else begin
          f = (sel == 2) ? pfd_ctrl[5:0] : pfd_ctrl[21:16];
          if (f == 0) begin
            err = 1;
            return;
          end
          p = (pll * 18) / f;
          if (sel == 3) p = p / 2;
        end
        if (id >= 2) p = p / (1 + bus_div_ctrl[12:10]);
        if (id >= 3) p = p / (1 + bus_div_ctrl[9:8]);
        if (id >= 4) p = p / (1 + per_div_ctrl[5:0]);
        hz = p & 64'hFFFF_FFFF;
      end
      default: hz = 0;
    endcase
  endfunction

  task automatic check(input string tag, input bit cond, input longint unsigned act,
                       input longint unsigned exp);
    n_checks++;
    if (!cond) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_resp(output bit got);
    int n = 0;
    while (!resp_valid && n < 2000) begin
      @(negedge clk);
      n++;
    end
    got = resp_valid;
  endtask

  task automatic run(input int id, input string tag);
    longint unsigned exp_hz;
    bit exp_err, got;
    model(id, exp_hz, exp_err);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid  = 1'b1;
    req_clk_id = 4'(id);
    @(negedge clk);
    req_valid = 1'b0;
    n_issued++;
    wait_resp(got);
    check({tag, " response seen"}, got, got, 1);
    check({tag, " value"}, resp_hz == exp_hz[31:0], resp_hz, exp_hz);
    check({tag, " error flag"}, resp_err == exp_err, resp_err, exp_err);
  endtask

  initial begin
    longint unsigned exp_hz;
    bit exp_err, got;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10 reset ready", req_ready == 1'b1, req_ready, 1);
    check("R10 reset valid", resp_valid == 1'b0, resp_valid, 0);

    pll_ctrl     = 32'h0000_0001;
    pfd_ctrl     = 32'h0018_001B;          // A=27, B=24
    bus_div_ctrl = 32'h0000_0900;          // bus field 2, ipg field 1, select 0
    per_div_ctrl = 32'h0000_0000;

    run(5, "R1 crystal");
    run(6, "R1 crystal/8");
    run(7, "R1 slow");
    run(0, "R8 id0");
    run(9, "R8 id9");
    run(15, "R8 id15");

    // R2 with both multiplier settings; R3 R4 R5 R6 R7 over all sources
    for (int m = 0; m < 2; m++) begin
      pll_ctrl = 32'(m);
      for (int s = 0; s < 4; s++) begin
        bus_div_ctrl = (32'(s) << 18) | 32'h0000_0900;
        per_div_ctrl = 32'd3;
        run(1, "R2 R3 R4 periph");
        run(2, "R5 bus");
        run(3, "R6 ipg");
        run(4, "R7 per");
      end
    end

    // R7 extreme divider fields, R11 truncation of each floor stage
    pll_ctrl     = 32'd0;
    pfd_ctrl     = 32'h0023_000D;          // A=13, B=35
    bus_div_ctrl = (32'd3 << 18) | (32'd7 << 10) | (32'd3 << 8);
    per_div_ctrl = 32'd63;
    run(4, "R7 max per field");
    run(3, "R11 odd chain");

    // R11 frequency exceeding 32 bits keeps its low word
    pfd_ctrl     = 32'h0001_0001;          // fractions 1
    bus_div_ctrl = 32'd2 << 18;
    run(1, "R11 wrap");

    // R9 zero fraction on selected source, then on the unselected one
    pfd_ctrl     = 32'h0018_0000;          // A=0, B=24
    bus_div_ctrl = 32'd2 << 18;
    run(1, "R9 zero fraction periph");
    run(4, "R9 zero fraction per");
    bus_div_ctrl = 32'd1 << 18;
    run(2, "R9 unselected zero");

    // R10: drive another id while busy; it must not be taken
    pfd_ctrl     = 32'h0018_001B;
    bus_div_ctrl = (32'd1 << 18) | 32'h0000_0900;
    per_div_ctrl = 32'd5;
    model(4, exp_hz, exp_err);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid  = 1'b1;
    req_clk_id = 4'd4;
    @(negedge clk);
    n_issued++;
    req_clk_id = 4'd5;
    for (int k = 0; k < 5; k++) begin
      check("R10 ready low while busy", req_ready == 1'b0, req_ready, 0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    wait_resp(got);
    check("R10 busy response seen", got, got, 1);
    check("R10 busy-window result", resp_hz == exp_hz[31:0], resp_hz, exp_hz);
    repeat (20) @(negedge clk);
    check("R10 one pulse per request", n_resps == n_issued, n_resps, n_issued);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule